// File: doc/BRIEF.md
# Zero-Padded 3x3 Median Filter

This block returns the 3x3 median around one pixel of a 16x16 RGB image. The image itself lives outside the block. A caller gives a centre row and column and pulses `start`. The block then walks the nine neighbourhood positions one per clock, in raster order, through a combinational read port. Each position that falls outside the image is replaced by zero, and no read is issued for it.

The red, green and blue samples are collected side by side. Each channel then passes through its own pipelined compare-and-swap median network, which has three registered stages. The three medians come out together with a one-cycle `done` pulse, and they stay on the outputs until the next result replaces them. A second `start` is accepted only once the block is idle again.

Top module: `median3x3_filter`

## Requirements
- R1: After reset `done`, `busy` and `rd_en` are all low.
- R2: A neighbour whose row or column lies outside 0..15 contributes the value 0 to the window. No read is issued for it: `rd_en` stays low in that tap's cycle.
- R3: Each channel's result equals the 5th smallest of its nine window values (zero padding and ties included).
- R4: Red, green and blue are filtered independently. Each result depends only on samples of the same channel.
- R5: Taps are visited one per clock in raster order: tap k has row offset k/3-1 and column offset k%3-1. Tap 0 is presented in the cycle right after the clock edge that accepts `start`. For in-image taps `rd_row` and `rd_col` carry the absolute row and column (0 = top and left).
- R6: `done` is high for exactly one cycle, 12 clock edges after the edge that accepts `start`. The medians stay unchanged until the next `done`.
- R7: `start` is accepted only while `busy` is low. A `start` raised while busy changes neither the running request nor its result, and produces no extra `done`.
- R8: `busy` rises on the accepting edge and falls on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled when idle |
| ctr_row | input | 4 | Centre pixel row |
| ctr_col | input | 4 | Centre pixel column |
| rd_en | output | 1 | Read request for an in-image tap |
| rd_row | output | 4 | Row address of the current tap |
| rd_col | output | 4 | Column address of the current tap |
| rd_r | input | 8 | Red sample at rd_row/rd_col, same cycle |
| rd_g | input | 8 | Green sample at rd_row/rd_col, same cycle |
| rd_b | input | 8 | Blue sample at rd_row/rd_col, same cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| med_r | output | 8 | Red median |
| med_g | output | 8 | Green median |
| med_b | output | 8 | Blue median |

## Verification
A wrong tap counter or wrong padding decision shows up within the nine gather cycles. It appears as a wrong or missing read address, or as a median that differs from the 5th-smallest value at border positions, where zeros push the result down. A misordered swap in the network corrupts the median that appears 12 edges after the request. Sweeping every centre position under images that contain ties and saturated values exposes it on the first window where that swap decides the outcome. Latency or pulse-width faults show up at the very first request.

// File: rtl/median_pkg.sv
package median_pkg;
  localparam int unsigned WIN_SIDE = 3;
  localparam int unsigned NUM_TAPS = WIN_SIDE * WIN_SIDE;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned TAP_W    = $clog2(NUM_TAPS + 1);
  localparam int unsigned PIPE_LAT = 3;
endpackage

// File: rtl/win_gather.sv
module win_gather
  import median_pkg::*;
#(
  parameter int unsigned IMG_DIM = 16,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned AW     = $clog2(IMG_DIM)
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        accept,
  input  logic [AW-1:0]                               row_in,
  input  logic [AW-1:0]                               col_in,
  input  logic [NUM_CH-1:0][DATA_W-1:0]               rd_data,
  output logic                                        rd_en,
  output logic [AW-1:0]                               rd_row,
  output logic [AW-1:0]                               rd_col,
  output logic [NUM_CH-1:0][NUM_TAPS-1:0][DATA_W-1:0] win,
  output logic                                        win_vld
);
  logic [AW-1:0]    row_q, col_q;
  logic [TAP_W-1:0] idx_q, idx_d;
  logic             act_q, act_d;
  logic             vld_d;
  logic [AW+1:0]    r_ext, c_ext;
  logic             inb;
  logic [NUM_CH-1:0][DATA_W-1:0]               sample;
  logic [NUM_CH-1:0][NUM_TAPS-1:0][DATA_W-1:0] win_q;

  always_comb begin
    r_ext = {2'b00, row_q} + (AW+2)'(idx_q / TAP_W'(WIN_SIDE)) - (AW+2)'(1);
    c_ext = {2'b00, col_q} + (AW+2)'(idx_q % TAP_W'(WIN_SIDE)) - (AW+2)'(1);
    inb   = (r_ext < (AW+2)'(IMG_DIM)) && (c_ext < (AW+2)'(IMG_DIM));
    for (int ch = 0; ch < NUM_CH; ch++)
      sample[ch] = inb ? rd_data[ch] : '0;
  end

  always_comb begin
    idx_d = idx_q;
    act_d = act_q;
    vld_d = 1'b0;
    if (accept) begin
      idx_d = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      idx_d = idx_q + TAP_W'(1);
      if (idx_q == TAP_W'(NUM_TAPS - 1)) begin
        act_d = 1'b0;
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      act_q   <= 1'b0;
      win_vld <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      idx_q   <= idx_d;
      act_q   <= act_d;
      win_vld <= vld_d;
      if (accept) begin
        row_q <= row_in;
        col_q <= col_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (act_q) begin
      for (int ch = 0; ch < NUM_CH; ch++)
        win_q[ch][idx_q] <= sample[ch];
    end
  end

  assign win    = win_q;
  assign rd_en  = act_q && inb;
  assign rd_row = r_ext[AW-1:0];
  assign rd_col = c_ext[AW-1:0];

  // R2: every issued read stays within one row and one column of the centre
  assert_read_near_centre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (({1'b0, rd_row} + 1'b1 >= {1'b0, row_q}) && ({1'b0, rd_row} <= {1'b0, row_q} + 1'b1)
            && ({1'b0, rd_col} + 1'b1 >= {1'b0, col_q}) && ({1'b0, rd_col} <= {1'b0, col_q} + 1'b1)));

  // R5: the window completes exactly when the tap walk ends
  assert_window_after_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> ($past(act_q) && !act_q));
endmodule

// File: rtl/median9_pipe.sv
module median9_pipe
  import median_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_vld,
  input  logic [NUM_TAPS-1:0][DATA_W-1:0]  taps,
  output logic                             out_vld,
  output logic [DATA_W-1:0]                med
);
  typedef logic [DATA_W-1:0] smp_t;

  smp_t s1_lo_q [WIN_SIDE], s1_mid_q [WIN_SIDE], s1_hi_q [WIN_SIDE];
  smp_t s1_lo_d [WIN_SIDE], s1_mid_d [WIN_SIDE], s1_hi_d [WIN_SIDE];
  smp_t s2_lo_q, s2_mid_q, s2_hi_q, s2_lo_d, s2_mid_d, s2_hi_d;
  smp_t med_q, med_d;
  logic s1_vld_q, s2_vld_q, out_vld_q;

  function automatic smp_t f_min(smp_t a, smp_t b);
    return (a < b) ? a : b;
  endfunction
  function automatic smp_t f_max(smp_t a, smp_t b);
    return (a < b) ? b : a;
  endfunction
  function automatic smp_t f_med3(smp_t a, smp_t b, smp_t c);
    return f_max(f_min(a, b), f_min(f_max(a, b), c));
  endfunction

  // Stage 1: sort each window row with three compare-swaps
  genvar gr;
  generate
    for (gr = 0; gr < WIN_SIDE; gr++) begin : g_row
      smp_t a1, b1, b2, c2;
      always_comb begin
        a1 = f_min(taps[gr*WIN_SIDE], taps[gr*WIN_SIDE+1]);
        b1 = f_max(taps[gr*WIN_SIDE], taps[gr*WIN_SIDE+1]);
        b2 = f_min(b1, taps[gr*WIN_SIDE+2]);
        c2 = f_max(b1, taps[gr*WIN_SIDE+2]);
        s1_lo_d[gr]  = f_min(a1, b2);
        s1_mid_d[gr] = f_max(a1, b2);
        s1_hi_d[gr]  = c2;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_lo_q[gr]  <= '0;
          s1_mid_q[gr] <= '0;
          s1_hi_q[gr]  <= '0;
        end else if (in_vld) begin
          s1_lo_q[gr]  <= s1_lo_d[gr];
          s1_mid_q[gr] <= s1_mid_d[gr];
          s1_hi_q[gr]  <= s1_hi_d[gr];
        end
      end
      // R3: each row leaves stage 1 in ascending order
      assert_row_sorted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld_q |-> (s1_lo_q[gr] <= s1_mid_q[gr]) && (s1_mid_q[gr] <= s1_hi_q[gr]));
    end
  endgenerate

  // Stage 2 and 3: pick from the column-wise anti-diagonal
  always_comb begin
    s2_lo_d  = f_max(f_max(s1_lo_q[0], s1_lo_q[1]), s1_lo_q[2]);
    s2_mid_d = f_med3(s1_mid_q[0], s1_mid_q[1], s1_mid_q[2]);
    s2_hi_d  = f_min(f_min(s1_hi_q[0], s1_hi_q[1]), s1_hi_q[2]);
    med_d    = f_med3(s2_lo_q, s2_mid_q, s2_hi_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s2_vld_q  <= 1'b0;
      out_vld_q <= 1'b0;
    end else begin
      s1_vld_q  <= in_vld;
      s2_vld_q  <= s1_vld_q;
      out_vld_q <= s2_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_lo_q  <= '0;
      s2_mid_q <= '0;
      s2_hi_q  <= '0;
    end else if (s1_vld_q) begin
      s2_lo_q  <= s2_lo_d;
      s2_mid_q <= s2_mid_d;
      s2_hi_q  <= s2_hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) med_q <= '0;
    else if (s2_vld_q) med_q <= med_d;
  end

  assign out_vld = out_vld_q;
  assign med     = med_q;

  // R6: the median only changes on a result strobe
  assert_med_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld_q |-> $stable(med_q));
endmodule

// File: rtl/median3x3_filter.sv
module median3x3_filter
  import median_pkg::*;
#(
  parameter int unsigned IMG_DIM = 16,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned AW     = $clog2(IMG_DIM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     ctr_row,
  input  logic [AW-1:0]     ctr_col,
  output logic              rd_en,
  output logic [AW-1:0]     rd_row,
  output logic [AW-1:0]     rd_col,
  input  logic [DATA_W-1:0] rd_r,
  input  logic [DATA_W-1:0] rd_g,
  input  logic [DATA_W-1:0] rd_b,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] med_r,
  output logic [DATA_W-1:0] med_g,
  output logic [DATA_W-1:0] med_b
);
  logic                                        busy_q, busy_d;
  logic                                        accept;
  logic                                        win_vld;
  logic [NUM_CH-1:0][NUM_TAPS-1:0][DATA_W-1:0] win;
  logic [NUM_CH-1:0][DATA_W-1:0]               rd_data;
  logic [NUM_CH-1:0][DATA_W-1:0]               med_all;
  logic [NUM_CH-1:0]                           ch_vld;

  assign accept  = start && !busy_q;
  assign rd_data = {rd_b, rd_g, rd_r};

  win_gather #(.IMG_DIM(IMG_DIM), .DATA_W(DATA_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .row_in(ctr_row), .col_in(ctr_col), .rd_data(rd_data),
    .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col),
    .win(win), .win_vld(win_vld)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
      median9_pipe #(.DATA_W(DATA_W)) u_med (
        .clk(clk), .rst_n(rst_n), .in_vld(win_vld), .taps(win[gc]),
        .out_vld(ch_vld[gc]), .med(med_all[gc])
      );
    end
  endgenerate

  always_comb begin
    busy_d = busy_q;
    if (accept)         busy_d = 1'b1;
    else if (ch_vld[0]) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  // The channel pipelines run in lockstep; done rises with the result.
  assign busy  = busy_q && !ch_vld[0];
  assign done  = ch_vld[0];
  assign med_r = med_all[0];
  assign med_g = med_all[1];
  assign med_b = med_all[2];

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_channels_lockstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ch_vld[0] |-> (ch_vld[1] && ch_vld[2]));
  assert_read_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

// File: tb/median3x3_filter_bench.sv
module median3x3_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [3:0] ctr_row, ctr_col;
  logic       rd_en;
  logic [3:0] rd_row, rd_col;
  logic [7:0] rd_r, rd_g, rd_b;
  logic       busy, done;
  logic [7:0] med_r, med_g, med_b;

  logic [7:0] img [3][256];
  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  assign rd_r = img[0][{rd_row, rd_col}];
  assign rd_g = img[1][{rd_row, rd_col}];
  assign rd_b = img[2][{rd_row, rd_col}];

  median3x3_filter u_median3x3_filter (
    .clk(clk), .rst_n(rst_n), .start(start), .ctr_row(ctr_row), .ctr_col(ctr_col),
    .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col),
    .rd_r(rd_r), .rd_g(rd_g), .rd_b(rd_b),
    .busy(busy), .done(done), .med_r(med_r), .med_g(med_g), .med_b(med_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pix(input int ch, input int r, input int c);
    if (r < 0 || r > 15 || c < 0 || c > 15) return 0;
    return int'(img[ch][r*16 + c]);
  endfunction

  function automatic int ref_med(input int ch, input int r, input int c);
    int v [9];
    int t;
    for (int k = 0; k < 9; k++) v[k] = pix(ch, r + k/3 - 1, c + k%3 - 1);
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 8 - i; j++)
        if (v[j] > v[j+1]) begin t = v[j]; v[j] = v[j+1]; v[j+1] = t; end
    return v[4];
  endfunction

  task automatic run_req(input int r, input int c, input bit full_checks);
    int cnt;
    int er, ec;
    bit inb;
    @(negedge clk);
    start = 1'b1; ctr_row = 4'(r); ctr_col = 4'(c);
    @(negedge clk);
    start = 1'b0;
    if (full_checks) check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    for (int k = 0; k < 9; k++) begin
      er  = r + k/3 - 1;
      ec  = c + k%3 - 1;
      inb = (er >= 0 && er <= 15 && ec >= 0 && ec <= 15);
      if (full_checks) begin
        check(rd_en == inb, inb ? "R5 tap read" : "R2 padded tap no read", int'(rd_en), int'(inb));
        if (inb) begin
          check(rd_row == 4'(er), "R5 rd_row", int'(rd_row), er);
          check(rd_col == 4'(ec), "R5 rd_col", int'(rd_col), ec);
        end
      end
      @(negedge clk);
    end
    cnt = 0;
    while (!done && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == 3, "R6 latency 12 edges", cnt + 9, 12);
    check(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
    check(int'(med_r) == ref_med(0, r, c), (r % 15 == 0 || c % 15 == 0) ? "R2 R3 red" : "R3 red", int'(med_r), ref_med(0, r, c));
    check(int'(med_g) == ref_med(1, r, c), "R4 green", int'(med_g), ref_med(1, r, c));
    check(int'(med_b) == ref_med(2, r, c), "R4 blue", int'(med_b), ref_med(2, r, c));
    if (full_checks) begin
      @(negedge clk);
      check(done == 1'b0, "R6 done one cycle", int'(done), 0);
      check(int'(med_r) == ref_med(0, r, c), "R6 result held", int'(med_r), ref_med(0, r, c));
    end
  endtask

  task automatic fill(input int pat);
    for (int i = 0; i < 256; i++) begin
      case (pat)
        0: begin
          img[0][i] = 8'((i/16)*7 + (i%16)*13);
          img[1][i] = 8'(i*37 + 11);
          img[2][i] = 8'(255 - i);
        end
        1: begin
          img[0][i] = 8'((((i/16) ^ (i%16)) & 3) * 60);
          img[1][i] = 8'((i % 3) * 100);
          img[2][i] = 8'((i*i) & 8'hC0);
        end
        default: begin
          img[0][i] = 8'd255;
          img[1][i] = 8'd1;
          img[2][i] = (i % 2 == 0) ? 8'd255 : 8'd0;
        end
      endcase
    end
  endtask

  initial begin
    #200000;
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; start = 1'b0; ctr_row = '0; ctr_col = '0;
    fill(0);
    repeat (3) @(negedge clk);
    check(done == 1'b0 && busy == 1'b0 && rd_en == 1'b0, "R1 reset outputs",
          int'({done, busy, rd_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      fill(p);
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 16; c++)
          run_req(r, c, p != 1);
    end
    // R7: a second strobe while busy leaves the request and result untouched
    fill(0);
    @(negedge clk);
    start = 1'b1; ctr_row = 4'd5; ctr_col = 4'd5;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; ctr_row = 4'd0; ctr_col = 4'd0;
    @(negedge clk);
    start = 1'b0;
    cnt = 4;
    while (!done && cnt < 30) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == 12, "R7 latency unchanged", cnt, 12);
    check(int'(med_g) == ref_med(1, 5, 5), "R7 result of first request", int'(med_g), ref_med(1, 5, 5));
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) cnt++;
    end
    check(cnt == 0, "R7 no extra done", cnt, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule